// File: doc/BRIEF.md
# Open-Drain Identity Vector Arbiter

Each repeater node in a stack shares a small backplane with its neighbours: an open-drain identity vector, an active-low activity line, a shared collision line and a bidirectional data path. This block is the per-node control logic for that backplane. At reset it captures a 5-bit node number from strap pins. When one of its local ports starts to receive, the node becomes the source. It pulls the activity line low and pulls down every vector line whose identity bit is 0, leaving the 1 bits to the pull-ups.

The node then reads the resolved vector back and compares it with its own number. A released 1 bit that reads 0 means another source is driving at the same time, so the node raises its collision output. Two or more local ports sensing carrier together also count as a collision. While the shared collision line is high, the node releases its vector pull-downs and its data drivers. It also produces the direction enable for the external data buffer, and a flag that shows it is listening to traffic that another node places on the backplane.

Top module: `vecbus_arbiter`

## Requirements
- R1: The node number is loaded from `node_id_pins` on every clock while `rst_n` is low and is held unchanged once `rst_n` is high. Later changes on the pins have no effect on `vec_pd_en`.
- R2: While the node is source and `coll_in` is low, `vec_pd_en[b]` is 1 exactly where bit b of the node number is 0. While the node is not source, `vec_pd_en` is 0.
- R3: While `coll_in` is high, `vec_pd_en` and `data_dir_en` are 0. With no pull-downs enabled anywhere, the resolved vector reads 5'h1F.
- R4: The node is source (`act_out_n` = 0) in the cycle after any bit of `port_crs` is 1, and idle (`act_out_n` = 1) in the cycle after all bits are 0.
- R5: Once the node has driven the vector for at least one full clock, a read-back that differs from its number sets `coll_out` at the next edge. A matching read-back never sets it.
- R6: With numbers 5'b00010 and 5'b00011 both driving, the vector reads 5'b00010 and only the 5'b00011 node raises `coll_out`. With 5'b00010 and 5'b00001, the vector reads 5'b00000 and both raise it.
- R7: Two or more bits of `port_crs` high at one edge set `coll_out` at that edge.
- R8: `coll_out` stays 1 while any `port_crs` bit is 1 and returns to 0 at the first edge with all bits 0.
- R9: `data_dir_en` = NOT(`act_out_n` OR `odir_req`), forced to 0 while `coll_in` is 1. When it is 1, the node drives backplane data. When it is 0, data flows from the backplane into the node.
- R10: `repeat_from_bus` is 1 exactly when `act_in_n` is 0 and the node is not source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; node number strapped while low |
| node_id_pins | input | ID_W (5) | Strap pins for the node number |
| port_crs | input | NPORTS (4) | Carrier sense, one per local port |
| coll_in | input | 1 | Shared collision line, active high |
| act_in_n | input | 1 | Resolved backplane activity line, active low |
| vec_rd | input | ID_W (5) | Read-back of the resolved identity vector |
| odir_req | input | 1 | Output-direction request for the data buffer |
| vec_pd_en | output | ID_W (5) | Per-bit pull-down enables for the vector lines |
| act_out_n | output | 1 | Activity pull-down, active low |
| coll_out | output | 1 | Collision raised by this node |
| data_dir_en | output | 1 | Data buffer enable toward the backplane |
| repeat_from_bus | output | 1 | Node is listening to backplane traffic |

## Verification
Assertions check several rules on every cycle: the held node number, no pull-downs while the collision line is high, source status following carrier, collision being sticky and then clearing, multi-carrier collision, a qualified read-back mismatch leading to a collision, and the data enable depending on source status. The wired-AND arithmetic of the shared vector can only be shown by the bench, which joins three nodes on a modelled bus. This covers which node of a pair sees the mismatch, the exact resolved values 5'b00010 and 5'b00000, and recovery of the surviving source once the collision ends. Randomised carrier patterns across the three nodes are compared cycle by cycle against a reference model kept in the bench.

// File: rtl/vecbus_pkg.sv
// Shared constants and types for the identity vector arbiter.
// Assumes: a single clock domain and a synchronous active-low reset.
package vecbus_pkg;
    localparam int unsigned VB_ID_W  = 5;
    localparam int unsigned VB_PORTS = 4;

    // Role of the node on the backplane
    typedef enum logic {
        VB_LISTEN = 1'b0,
        VB_SOURCE = 1'b1
    } vb_role_e;
endpackage

// File: rtl/vecbus_id_latch.sv
// Captures the node number from strap pins while reset is held and keeps
// it constant afterwards. Assumes: the pins are stable during reset.
module vecbus_id_latch #(
    parameter int unsigned ID_W = vecbus_pkg::VB_ID_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] id_pins,
    output logic [ID_W-1:0] id_q
);
    // Sample straps during reset, hold after release
    always_ff @(posedge clk) begin
        if (!rst_n) id_q <= id_pins;
    end

    // R1
    id_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(id_q));
endmodule

// File: rtl/vecbus_crs_eval.sv
// Reduces the local carrier-sense lines into "any carrier" and "two or
// more carriers". Assumes: lines are already synchronous to clk.
module vecbus_crs_eval #(
    parameter int unsigned NPORTS = vecbus_pkg::VB_PORTS
) (
    input  logic [NPORTS-1:0] port_crs,
    output logic              crs_any,
    output logic              crs_multi
);
    logic [NPORTS:0] seen;
    logic [NPORTS:0] dup;

    assign seen[0] = 1'b0;
    assign dup[0]  = 1'b0;

    // One stage per port: a carrier after an earlier one marks a duplicate
    for (genvar p = 0; p < NPORTS; p++) begin : g_stage
        assign seen[p+1] = seen[p] | port_crs[p];
        assign dup[p+1]  = dup[p] | (seen[p] & port_crs[p]);
    end

    assign crs_any   = seen[NPORTS];
    assign crs_multi = dup[NPORTS];
endmodule

// File: rtl/vecbus_contention.sv
// Tracks source status, qualifies the vector read-back after one clock
// of driving, and keeps the collision flag until local carrier ends.
// Assumes: vec_rd is the resolved wired-AND value of the vector lines.
module vecbus_contention #(
    parameter int unsigned ID_W   = vecbus_pkg::VB_ID_W,
    parameter int unsigned NPORTS = vecbus_pkg::VB_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   node_id,
    input  logic [NPORTS-1:0] port_crs,
    input  logic              crs_any,
    input  logic              crs_multi,
    input  logic              coll_in,
    input  logic [ID_W-1:0]   vec_rd,
    output logic              active,
    output logic              drive,
    output logic              coll_out
);
    import vecbus_pkg::*;

    vb_role_e role_q;
    logic     drive_q;
    logic     coll_q;
    logic     mismatch;

    assign active   = (role_q == VB_SOURCE);
    assign drive    = active & ~coll_in;
    assign mismatch = drive & drive_q & (vec_rd != node_id);
    assign coll_out = coll_q;

    // Source role follows local carrier with one register of delay
    always_ff @(posedge clk) begin
        if (!rst_n) role_q <= VB_LISTEN;
        else        role_q <= crs_any ? VB_SOURCE : VB_LISTEN;
    end

    // Remembers that the vector was driven in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= drive;
    end

    // Sticky collision flag, cleared when all local carrier is gone
    always_ff @(posedge clk) begin
        if (!rst_n) coll_q <= 1'b0;
        else        coll_q <= crs_any & (coll_q | mismatch | crs_multi);
    end

    // R4
    src_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_crs) |=> active);
    // R5
    mismatch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && drive_q && vec_rd != node_id && (|port_crs)) |=> coll_out);
    // R7
    multi_crs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(port_crs) > 1) |=> coll_out);
    // R8
    coll_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_out && (|port_crs)) |=> coll_out);
    // R8
    coll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|port_crs) |=> !coll_out);
endmodule

// File: rtl/vecbus_arbiter.sv
// Per-node controller for a shared open-drain identity vector, activity
// and collision backplane. Assumes: all backplane inputs are resolved and
// synchronous to clk; pull-ups exist outside the block.
module vecbus_arbiter #(
    parameter int unsigned ID_W   = vecbus_pkg::VB_ID_W,
    parameter int unsigned NPORTS = vecbus_pkg::VB_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   node_id_pins,
    input  logic [NPORTS-1:0] port_crs,
    input  logic              coll_in,
    input  logic              act_in_n,
    input  logic [ID_W-1:0]   vec_rd,
    input  logic              odir_req,
    output logic [ID_W-1:0]   vec_pd_en,
    output logic              act_out_n,
    output logic              coll_out,
    output logic              data_dir_en,
    output logic              repeat_from_bus
);
    logic [ID_W-1:0] node_id;
    logic            crs_any;
    logic            crs_multi;
    logic            active;
    logic            drive;

    vecbus_id_latch #(.ID_W(ID_W)) u_id (
        .clk     (clk),
        .rst_n   (rst_n),
        .id_pins (node_id_pins),
        .id_q    (node_id)
    );

    vecbus_crs_eval #(.NPORTS(NPORTS)) u_crs (
        .port_crs  (port_crs),
        .crs_any   (crs_any),
        .crs_multi (crs_multi)
    );

    vecbus_contention #(.ID_W(ID_W), .NPORTS(NPORTS)) u_cont (
        .clk       (clk),
        .rst_n     (rst_n),
        .node_id   (node_id),
        .port_crs  (port_crs),
        .crs_any   (crs_any),
        .crs_multi (crs_multi),
        .coll_in   (coll_in),
        .vec_rd    (vec_rd),
        .active    (active),
        .drive     (drive),
        .coll_out  (coll_out)
    );

    // Pull down only the zero bits of the node number while driving
    always_comb begin
        vec_pd_en = drive ? ~node_id : '0;
    end

    // Activity, data direction and listener flag
    always_comb begin
        act_out_n       = ~active;
        data_dir_en     = ~(act_out_n | odir_req) & ~coll_in;
        repeat_from_bus = ~act_in_n & ~active;
    end

    // R3
    release_on_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coll_in |-> (vec_pd_en == '0 && !data_dir_en));
    // R9
    dir_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_dir_en |-> (!act_out_n && !odir_req));
    // R2
    idle_no_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_out_n |-> (vec_pd_en == '0));
endmodule

// File: tb/test_vecbus_arbiter.sv
// Three nodes on a modelled wired-AND backplane, compared against a
// cycle model kept in the bench.
module test_vecbus_arbiter;
    localparam int N  = 3;
    localparam int IW = 5;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [IW-1:0] id_pins [N];
    logic [NP-1:0] crs     [N];
    logic          odir    [N];
    logic [IW-1:0] pd_en   [N];
    logic          act_n   [N];
    logic          coll    [N];
    logic          dden    [N];
    logic          rep     [N];

    logic [IW-1:0] bus;
    logic          coll_bus;
    logic          act_bus_n;

    // Wired-AND resolution of the shared lines
    always_comb begin
        bus       = '1;
        coll_bus  = 1'b0;
        act_bus_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            bus       = bus & ~pd_en[i];
            coll_bus  = coll_bus | coll[i];
            act_bus_n = act_bus_n & act_n[i];
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_node
        vecbus_arbiter #(.ID_W(IW), .NPORTS(NP)) i_vecbus_arbiter (
            .clk             (clk),
            .rst_n           (rst_n),
            .node_id_pins    (id_pins[k]),
            .port_crs        (crs[k]),
            .coll_in         (coll_bus),
            .act_in_n        (act_bus_n),
            .vec_rd          (bus),
            .odir_req        (odir[k]),
            .vec_pd_en       (pd_en[k]),
            .act_out_n       (act_n[k]),
            .coll_out        (coll[k]),
            .data_dir_en     (dden[k]),
            .repeat_from_bus (rep[k])
        );
    end

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state
    logic [IW-1:0] m_id  [N];
    logic          m_act [N];
    logic          m_dq  [N];
    logic          m_col [N];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic m_cin();
        logic c = 1'b0;
        for (int i = 0; i < N; i++) c = c | m_col[i];
        return c;
    endfunction

    function automatic logic [IW-1:0] m_pd(input int i);
        return (m_act[i] && !m_cin()) ? ~m_id[i] : '0;
    endfunction

    // Compare every output of every node with the model
    task automatic check_all();
        logic any_act = 1'b0;
        for (int i = 0; i < N; i++) any_act = any_act | m_act[i];
        for (int i = 0; i < N; i++) begin
            chk("R2", "vec_pd_en", 32'(pd_en[i]), 32'(m_pd(i)));
            chk("R4", "act_out_n", 32'(act_n[i]), 32'(!m_act[i]));
            chk("R5", "coll_out", 32'(coll[i]), 32'(m_col[i]));
            chk("R9", "data_dir_en", 32'(dden[i]),
                32'(m_act[i] && !odir[i] && !m_cin()));
            chk("R10", "repeat_from_bus", 32'(rep[i]), 32'(any_act && !m_act[i]));
        end
    endtask

    // Apply current inputs across one edge and advance the model
    task automatic step();
        logic          cin;
        logic [IW-1:0] mbus;
        logic          drv [N];
        logic          n_act [N];
        logic          n_dq [N];
        logic          n_col [N];
        cin  = m_cin();
        mbus = '1;
        for (int i = 0; i < N; i++) begin
            drv[i] = m_act[i] && !cin;
            mbus   = mbus & (drv[i] ? m_id[i] | ~m_id[i] & '0 : '1);
        end
        for (int i = 0; i < N; i++) begin
            logic mism, multi, anyc;
            mism     = drv[i] && m_dq[i] && (mbus != m_id[i]);
            multi    = ($countones(crs[i]) > 1);
            anyc     = |crs[i];
            n_act[i] = anyc;
            n_dq[i]  = drv[i];
            n_col[i] = anyc && (m_col[i] || mism || multi);
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            m_act[i] = n_act[i];
            m_dq[i]  = n_dq[i];
            m_col[i] = n_col[i];
        end
        check_all();
    endtask

    task automatic idle_all();
        for (int i = 0; i < N; i++) crs[i] = '0;
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'h1AB5_0C07));
        m_id[0] = 5'b00010;
        m_id[1] = 5'b00011;
        m_id[2] = 5'b00001;
        for (int i = 0; i < N; i++) begin
            id_pins[i] = m_id[i];
            crs[i]     = '0;
            odir[i]    = 1'b0;
            m_act[i]   = 1'b0;
            m_dq[i]    = 1'b0;
            m_col[i]   = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: straps change after release and must be ignored
        for (int i = 0; i < N; i++) id_pins[i] = 5'b11111 ^ m_id[i];
        check_all();
        chk("R3", "idle bus", 32'(bus), 32'h1F);

        // Lone source: node 0 drives its number
        crs[0] = 4'b0001;
        step();
        chk("R1", "pd after strap change", 32'(pd_en[0]), 32'(~5'b00010 & 5'h1F));
        step(); step();
        chk("R5", "lone source read-back", 32'(bus), 32'h02);
        chk("R5", "lone source no coll", 32'(coll[0]), 32'h0);

        // R6: 00010 first, then 00011 joins
        crs[1] = 4'b0100;
        step();
        chk("R6", "pair bus 00010/00011", 32'(bus), 32'h02);
        step(); step();
        chk("R6", "00011 node coll", 32'(coll[1]), 32'h1);
        chk("R6", "00010 node no coll", 32'(coll[0]), 32'h0);
        chk("R3", "bus released on coll", 32'(bus), 32'h1F);
        step();
        chk("R8", "coll held", 32'(coll[1]), 32'h1);
        crs[1] = '0;
        step();
        chk("R8", "coll cleared", 32'(coll[1]), 32'h0);
        step();
        chk("R6", "survivor drives again", 32'(bus), 32'h02);
        idle_all();
        step(); step();

        // R6: 00010 and 00001 together
        crs[0] = 4'b0010;
        crs[2] = 4'b1000;
        step();
        chk("R6", "pair bus 00010/00001", 32'(bus), 32'h00);
        step(); step();
        chk("R6", "00010 node coll", 32'(coll[0]), 32'h1);
        chk("R6", "00001 node coll", 32'(coll[2]), 32'h1);
        idle_all();
        step(); step();

        // R7: two local carriers on one node
        crs[2] = 4'b0101;
        step();
        chk("R7", "multi carrier coll", 32'(coll[2]), 32'h1);
        crs[2] = 4'b0001;
        step();
        chk("R8", "coll kept with one carrier", 32'(coll[2]), 32'h1);
        idle_all();
        step();

        // R9 with direction request, R10 listener flag
        crs[1]  = 4'b0010;
        odir[1] = 1'b1;
        step();
        chk("R9", "odir blocks data", 32'(dden[1]), 32'h0);
        chk("R10", "listener node 0", 32'(rep[0]), 32'h1);
        odir[1] = 1'b0;
        step();
        chk("R9", "source drives data", 32'(dden[1]), 32'h1);
        idle_all();
        step(); step();

        // Random phase
        for (int t = 0; t < 400; t++) begin
            for (int i = 0; i < N; i++) begin
                int r;
                r = int'($urandom % 16);
                if (r < 9)       crs[i] = crs[i];
                else if (r < 12) crs[i] = '0;
                else if (r < 15) crs[i] = 4'(1 << ($urandom % NP));
                else             crs[i] = 4'($urandom);
                odir[i] = ($urandom % 5 == 0);
            end
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule